// File: doc/BRIEF.md
# Dual-Counter Multi-Mode Timer

This block is a timer core built around two down-counters and two reload/capture registers. The same four storage elements serve four modes. In the pulse-width mode, pin A is driven as a free-running pulse train. In the dual-capture mode, edges on pins A and B latch the first counter into the two registers. In the dual-timer mode, the two counters run as independent periodic timers. In the single-capture mode, edges on pin A are captured while the second counter runs as a periodic timer. A separate clock-source block supplies one single-cycle count enable per counter. Software-side strobes load the counters and registers directly.

Each counter decrements on its count enable. When a counter is at zero and its enable arrives, it reloads from a value that depends on the mode, and an underflow event fires. Capture inputs pass through a synchronizer and a polarity-selectable edge detector. Four event flags feed two interrupt lines through per-flag enables, and the flags are cleared by write-one-to-clear pulses.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset, both counters, both registers and all four flags are zero, and ta_out, irq_a and irq_b are low.
- R2: A counter that is not zero decrements by one in each cycle its count enable (tick1 or tick2) is high, and it holds its value in cycles without the enable.
- R3: In mode 2 (dual timer), counter 1 at zero with tick1 reloads from register A, and counter 2 at zero with tick2 reloads from register B, so a reload value R gives a period of R+1 ticks.
- R4: In modes 0 and 1 each counter wraps from zero to all ones. In mode 3 counter 1 wraps and counter 2 reloads from register B.
- R5: In mode 0 (pulse width), ta_oe is high and ta_out starts low. Each counter 1 underflow toggles ta_out and reloads counter 1 from register A when ta_out goes high and from register B when it goes low, giving A+1 ticks high and B+1 ticks low. In every other mode ta_oe and ta_out are low.
- R6: In mode 1 (dual capture), a selected edge on ta_in copies counter 1 into register A, and a selected edge on tb_in copies it into register B. In mode 3 only ta_in captures (into register A). The polarity inputs select a rising edge (1) or a falling edge (0), and the register updates on the third rising clock edge after the pin changes.
- R7: Pin edges are ignored for capture in modes 0 and 2 on both pins, and on tb_in in mode 3; edges of the unselected polarity are ignored in every mode.
- R8: Flag bit 0 is set by a capture into register A, or in mode 0 when ta_out rises. Bit 1 is set by a capture into register B, or in mode 0 when ta_out falls. Bit 2 is set by a counter 1 underflow outside mode 0. Bit 3 is set by every counter 2 underflow.
- R9: irq_a is high while flag 0 or flag 2 is set together with its int_en bit; irq_b is high while flag 1 or flag 3 is set together with its int_en bit.
- R10: A one in flag_clr clears that flag on the next clock edge. When a set and a clear of the same flag occur in one cycle, the flag ends up set.
- R11: A counter load strobe takes priority over counting, and a register load strobe takes priority over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 0 pulse width, 1 dual capture, 2 dual timer, 3 single capture |
| tick1 | input | 1 | Count enable for counter 1 |
| tick2 | input | 1 | Count enable for counter 2 |
| ta_in | input | 1 | Pin A input level |
| tb_in | input | 1 | Pin B input level |
| ta_rise | input | 1 | Pin A capture polarity, 1 rising, 0 falling |
| tb_rise | input | 1 | Pin B capture polarity, 1 rising, 0 falling |
| wr_cnt1 | input | 1 | Load counter 1 from wdata |
| wr_cnt2 | input | 1 | Load counter 2 from wdata |
| wr_cra | input | 1 | Load register A from wdata |
| wr_crb | input | 1 | Load register B from wdata |
| wdata | input | 16 | Load value |
| int_en | input | 4 | Interrupt enable per flag |
| flag_clr | input | 4 | Write-one-to-clear pulses per flag |
| cnt1_o | output | 16 | Counter 1 value |
| cnt2_o | output | 16 | Counter 2 value |
| cra_o | output | 16 | Register A value |
| crb_o | output | 16 | Register B value |
| flags_o | output | 4 | Event flags |
| irq_a | output | 1 | Interrupt request A |
| irq_b | output | 1 | Interrupt request B |
| ta_out | output | 1 | Pin A output level |
| ta_oe | output | 1 | Pin A output enable |

## Verification
The bench builds the block with its defaults: a 16-bit counter width and a two-stage synchronizer. With two stages, a pin change reaches a register exactly three clock edges later, so one write strobe can be placed on the same edge as a capture to test write priority. At 16 bits, a wrap from zero lands on 0xFFFF. Small reload values (0 to 9) keep full reload periods and pulse trains short enough to observe several complete periods.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  typedef enum logic [1:0] {
    MD_PWM  = 2'd0,
    MD_DCAP = 2'd1,
    MD_DTMR = 2'd2,
    MD_SCAP = 2'd3
  } tmr_mode_e;

  localparam int NFLAG = 4;
  localparam int FL_A  = 0;
  localparam int FL_B  = 1;
  localparam int FL_U1 = 2;
  localparam int FL_U2 = 3;

  localparam logic [NFLAG-1:0] MASK_IRQ_A = 4'b0101;
  localparam logic [NFLAG-1:0] MASK_IRQ_B = 4'b1010;

  // sticky flag update: set dominates clear
  function automatic logic [NFLAG-1:0] flag_next(input logic [NFLAG-1:0] cur,
                                                 input logic [NFLAG-1:0] set,
                                                 input logic [NFLAG-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic irq_of(input logic [NFLAG-1:0] flg,
                                  input logic [NFLAG-1:0] en,
                                  input logic [NFLAG-1:0] mask);
    return |(flg & en & mask);
  endfunction

endpackage

// File: rtl/dmt_edge_det.sv
module dmt_edge_det #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic evt
);
  localparam int LAST = SYNC;

  logic [LAST:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[LAST-1:0], pin};
  end

  logic cur_lvl, prev_lvl;
  assign cur_lvl  = sh[LAST-1];
  assign prev_lvl = sh[LAST];
  assign evt = rise_sel ? (cur_lvl & ~prev_lvl) : (~cur_lvl & prev_lvl);
endmodule

// File: rtl/dmt_down_cnt.sv
module dmt_down_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] rld_val,
  output logic [W-1:0] cnt,
  output logic         uf
);
  function automatic logic [W-1:0] step(input logic [W-1:0] cur,
                                        input logic [W-1:0] rld);
    return (cur == '0) ? rld : cur - 1'b1;
  endfunction

  assign uf = tick & ~load & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= step(cnt, rld_val);
  end
endmodule

// File: rtl/dmt_flags.sv
module dmt_flags
  import dmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set,
  input  logic [NFLAG-1:0] clr,
  input  logic [NFLAG-1:0] en,
  output logic [NFLAG-1:0] flags,
  output logic             irq_a,
  output logic             irq_b
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flag_next(flags, set, clr);
  end

  assign irq_a = irq_of(flags, en, MASK_IRQ_A);
  assign irq_b = irq_of(flags, en, MASK_IRQ_B);
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import dmt_pkg::*;
#(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         tick1,
  input  logic         tick2,
  input  logic         ta_in,
  input  logic         tb_in,
  input  logic         ta_rise,
  input  logic         tb_rise,
  input  logic         wr_cnt1,
  input  logic         wr_cnt2,
  input  logic         wr_cra,
  input  logic         wr_crb,
  input  logic [W-1:0] wdata,
  input  logic [3:0]   int_en,
  input  logic [3:0]   flag_clr,
  output logic [W-1:0] cnt1_o,
  output logic [W-1:0] cnt2_o,
  output logic [W-1:0] cra_o,
  output logic [W-1:0] crb_o,
  output logic [3:0]   flags_o,
  output logic         irq_a,
  output logic         irq_b,
  output logic         ta_out,
  output logic         ta_oe
);
  localparam int NCNT = 2;
  localparam logic [W-1:0] ALL_ONES = '1;

  tmr_mode_e md;
  assign md = tmr_mode_e'(mode);

  logic is_pwm, is_dcap, is_dtmr, is_scap;
  assign is_pwm  = (md == MD_PWM);
  assign is_dcap = (md == MD_DCAP);
  assign is_dtmr = (md == MD_DTMR);
  assign is_scap = (md == MD_SCAP);

  // ---- pin edge detection ----
  logic evt_a, evt_b;
  dmt_edge_det #(.SYNC(SYNC)) u_edge_a (
    .clk(clk), .rst_n(rst_n), .pin(ta_in), .rise_sel(ta_rise), .evt(evt_a));
  dmt_edge_det #(.SYNC(SYNC)) u_edge_b (
    .clk(clk), .rst_n(rst_n), .pin(tb_in), .rise_sel(tb_rise), .evt(evt_b));

  logic cap_a, cap_b;
  assign cap_a = evt_a & (is_dcap | is_scap);
  assign cap_b = evt_b & is_dcap;

  // ---- registers A / B ----
  logic [W-1:0] cra_q, crb_q;
  logic [W-1:0] cnt [NCNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cra_q <= '0;
      crb_q <= '0;
    end else begin
      if (wr_cra)     cra_q <= wdata;
      else if (cap_a) cra_q <= cnt[0];
      if (wr_crb)     crb_q <= wdata;
      else if (cap_b) crb_q <= cnt[0];
    end
  end

  // ---- pulse output state ----
  logic ta_q;

  // ---- reload selection per mode ----
  logic [W-1:0] rld [NCNT];
  always_comb begin
    unique case (md)
      MD_PWM:  rld[0] = ta_q ? crb_q : cra_q;
      MD_DTMR: rld[0] = cra_q;
      default: rld[0] = ALL_ONES;
    endcase
    rld[1] = (is_dtmr | is_scap) ? crb_q : ALL_ONES;
  end

  // ---- counters ----
  logic [NCNT-1:0] tick_v, load_v, uf_v;
  assign tick_v = {tick2, tick1};
  assign load_v = {wr_cnt2, wr_cnt1};

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    dmt_down_cnt #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .tick(tick_v[i]), .load(load_v[i]),
      .load_val(wdata), .rld_val(rld[i]),
      .cnt(cnt[i]), .uf(uf_v[i]));
  end

  logic c1_uf, c2_uf;
  assign c1_uf = uf_v[0];
  assign c2_uf = uf_v[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ta_q <= 1'b0;
    else if (!is_pwm) ta_q <= 1'b0;
    else if (c1_uf)   ta_q <= ~ta_q;
  end

  // ---- flags ----
  logic [NFLAG-1:0] fset;
  always_comb begin
    fset        = '0;
    fset[FL_A]  = is_pwm ? (c1_uf & ~ta_q) : cap_a;
    fset[FL_B]  = is_pwm ? (c1_uf & ta_q)  : cap_b;
    fset[FL_U1] = c1_uf & ~is_pwm;
    fset[FL_U2] = c2_uf;
  end

  dmt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set(fset), .clr(flag_clr), .en(int_en),
    .flags(flags_o), .irq_a(irq_a), .irq_b(irq_b));

  assign cnt1_o = cnt[0];
  assign cnt2_o = cnt[1];
  assign cra_o  = cra_q;
  assign crb_o  = crb_q;
  assign ta_out = ta_q;
  assign ta_oe  = is_pwm;
endmodule

// File: rtl/dual_mode_timer_chk.sv
module dual_mode_timer_chk
  import dmt_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic         tick1,
  input logic         wr_cnt1,
  input logic         wr_cra,
  input logic [W-1:0] cnt1,
  input logic [W-1:0] cra,
  input logic         ta_out,
  input logic         c1_uf,
  input logic         c2_uf,
  input logic         cap_a,
  input logic [3:0]   flags
);
  assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick1 && !wr_cnt1 && cnt1 != '0) |=> cnt1 == $past(cnt1) - 1'b1);

  assert_timer_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_DTMR && c1_uf) |=> cnt1 == $past(cra));

  assert_capture_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_DCAP && c1_uf) |=> cnt1 == {W{1'b1}});

  assert_pwm_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PWM && !c1_uf) |=> $stable(ta_out));

  assert_capture_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_a && !wr_cra) |=> cra == $past(cnt1));

  assert_uf2_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    c2_uf |=> flags[FL_U2]);
endmodule

bind dual_mode_timer dual_mode_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .tick1(tick1), .wr_cnt1(wr_cnt1),
  .wr_cra(wr_cra), .cnt1(cnt1_o), .cra(cra_o), .ta_out(ta_out),
  .c1_uf(c1_uf), .c2_uf(c2_uf), .cap_a(cap_a), .flags(flags_o));

// File: tb/dual_mode_timer_tb.sv
module dual_mode_timer_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd2;
  logic tick1 = 0, tick2 = 0, ta_in = 0, tb_in = 0, ta_rise = 1, tb_rise = 1;
  logic wr_cnt1 = 0, wr_cnt2 = 0, wr_cra = 0, wr_crb = 0;
  logic [W-1:0] wdata = '0;
  logic [3:0] int_en = '0, flag_clr = '0;
  logic [W-1:0] cnt1_o, cnt2_o, cra_o, crb_o;
  logic [3:0] flags_o;
  logic irq_a, irq_b, ta_out, ta_oe;

  always #4 clk = ~clk;

  dual_mode_timer u_dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sel: 0 cnt1, 1 cnt2, 2 cra, 3 crb
  task automatic load(input int sel, input logic [W-1:0] v);
    wdata = v;
    case (sel)
      0: wr_cnt1 = 1;
      1: wr_cnt2 = 1;
      2: wr_cra = 1;
      default: wr_crb = 1;
    endcase
    step(1);
    wr_cnt1 = 0; wr_cnt2 = 0; wr_cra = 0; wr_crb = 0;
  endtask

  task automatic clear_all();
    flag_clr = 4'hF; step(1); flag_clr = 4'h0;
  endtask

  task automatic t1(input int n); tick1 = 1; step(n); tick1 = 0; endtask
  task automatic t2(input int n); tick2 = 1; step(n); tick2 = 0; endtask

  // {initial count, reload, ticks, expected} for the dual-timer period check (R3)
  localparam logic [63:0] VEC [0:7] = '{
    {16'd5,  16'd3, 16'd2,  16'd3},
    {16'd5,  16'd3, 16'd5,  16'd0},
    {16'd5,  16'd3, 16'd6,  16'd3},
    {16'd5,  16'd3, 16'd9,  16'd0},
    {16'd5,  16'd3, 16'd10, 16'd3},
    {16'd0,  16'd7, 16'd1,  16'd7},
    {16'd10, 16'd0, 16'd12, 16'd0},
    {16'd2,  16'd9, 16'd20, 16'd2}
  };

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic samp [0:29];
    int i0, hi, lo;
    logic [W-1:0] keep;
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    chk("R1 cnt1", cnt1_o, 0);
    chk("R1 cnt2", cnt2_o, 0);
    chk("R1 cra", cra_o, 0);
    chk("R1 crb", crb_o, 0);
    chk("R1 flags", flags_o, 0);
    chk("R1 irq", {irq_a, irq_b}, 0);
    chk("R1 ta_out", ta_out, 0);
    chk("R5 oe off in mode 2", ta_oe, 0);

    // R3 vector table, mode 2
    for (int v = 0; v < 8; v++) begin
      load(3, VEC[v][47:32]);
      load(1, VEC[v][63:48]);
      t2(int'(VEC[v][31:16]));
      chk($sformatf("R3 vector %0d cnt2", v), cnt2_o, VEC[v][15:0]);
    end

    // R2 hold without tick
    keep = cnt2_o;
    step(3);
    chk("R2 hold", cnt2_o, keep);
    load(1, 16'd9);
    t2(4);
    chk("R2 decrement", cnt2_o, 5);

    // R3/R8/R9/R10 counter 1 reload and flag
    clear_all();
    int_en = 4'b0100;
    load(2, 16'd4);
    load(0, 16'd1);
    t1(2);
    chk("R3 cnt1 reload", cnt1_o, 4);
    chk("R8 flag u1", flags_o, 4'b0100);
    chk("R9 irq_a", irq_a, 1);
    chk("R9 irq_b", irq_b, 0);
    flag_clr = 4'b0100; step(1); flag_clr = 0;
    chk("R10 clear", flags_o, 0);
    chk("R9 irq_a low", irq_a, 0);

    // R10 set beats clear
    load(1, 16'd0);
    tick2 = 1; flag_clr = 4'b1000; step(1); tick2 = 0; flag_clr = 0;
    chk("R10 set wins", flags_o[3], 1);
    int_en = 4'b1000; step(1);
    chk("R9 irq_b", irq_b, 1);
    int_en = 0;

    // R11 counter write beats tick
    wdata = 16'h0055; wr_cnt1 = 1; tick1 = 1; step(1); wr_cnt1 = 0; tick1 = 0;
    chk("R11 load over tick", cnt1_o, 16'h0055);

    // R5 pulse mode
    load(2, 16'd2);
    load(3, 16'd1);
    load(0, 16'd0);
    mode = 2'd0;
    step(1);
    clear_all();
    chk("R5 oe on", ta_oe, 1);
    chk("R5 starts low", ta_out, 0);
    tick1 = 1;
    for (int k = 0; k < 30; k++) begin step(1); samp[k] = ta_out; end
    tick1 = 0;
    i0 = 1;
    while (i0 < 30 && !(samp[i0] && !samp[i0-1])) i0++;
    hi = 0; while (i0 < 30 && samp[i0]) begin hi++; i0++; end
    lo = 0; while (i0 < 30 && !samp[i0]) begin lo++; i0++; end
    chk("R5 high ticks", hi, 3);
    chk("R5 low ticks", lo, 2);
    chk("R8 pwm edge flags", flags_o[1:0], 2'b11);

    // R7 no capture in pulse mode
    ta_rise = 1; ta_in = 1; step(4);
    chk("R7 pwm ignores ta_in", cra_o, 2);

    // R4 counter 2 wraps in mode 0
    load(1, 16'd0);
    t2(1);
    chk("R4 cnt2 wrap", cnt2_o, 16'hFFFF);

    // R6 dual capture
    mode = 2'd1; step(1);
    chk("R5 oe off in mode 1", ta_oe, 0);
    chk("R5 out low off mode 0", ta_out, 0);
    clear_all();
    ta_rise = 0;
    load(0, 16'h1234);
    ta_in = 0; step(4);
    chk("R6 falling capture A", cra_o, 16'h1234);
    chk("R8 flag A", flags_o, 4'b0001);
    tb_rise = 1;
    load(0, 16'h00AB);
    tb_in = 1; step(4);
    chk("R6 rising capture B", crb_o, 16'h00AB);
    chk("R8 flag B", flags_o[1], 1);
    load(0, 16'h0777);
    tb_in = 0; step(4);
    chk("R7 wrong polarity ignored", crb_o, 16'h00AB);

    // R4 counter 1 wraps in mode 1
    clear_all();
    load(0, 16'd0);
    t1(1);
    chk("R4 cnt1 wrap", cnt1_o, 16'hFFFF);
    chk("R8 flag u1 mode 1", flags_o, 4'b0100);

    // R11 register write beats capture
    load(0, 16'h0BAD);
    ta_rise = 1; ta_in = 1; step(2);
    wdata = 16'h0C0D; wr_cra = 1; step(1); wr_cra = 0;
    chk("R11 write over capture", cra_o, 16'h0C0D);

    // R7/R6 single capture mode
    mode = 2'd3; step(1);
    clear_all();
    load(0, 16'h0999);
    tb_rise = 1; tb_in = 1; step(4);
    chk("R7 tb ignored mode 3", crb_o, 16'h00AB);
    chk("R7 no flag B mode 3", flags_o[1], 0);
    ta_rise = 0; ta_in = 0; step(4);
    chk("R6 capture A mode 3", cra_o, 16'h0999);
    load(1, 16'd0);
    t2(1);
    chk("R4 cnt2 reload mode 3", cnt2_o, 16'h00AB);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule